// File: doc/BRIEF.md
# Single-Wire Frame Parser

This block sits behind a symbol decoder on a one-wire serial link. Each cycle it may receive one classified symbol: a data zero, a data one, an idle marker (D), a line-low filler (L) or an invalid symbol. It assembles these symbols into frames. A frame carries one routing tag, a 16-bit payload and two parity symbols. When a frame is good, the block emits a one-cycle write strobe. The write goes either to the converter word or to a configuration register, where the high payload byte is the address and the low byte is the data.

Malformed frames produce a one-cycle framing-error or parity-error pulse instead of a write. A write can also raise an acknowledge request, so that the front end can send a reply pulse. Symbol timing and the register file are handled elsewhere.

Top module: `swire_frame_parser`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, all strobes (`dac_we`, `cfg_we`, `frame_err`, `parity_err`, `ack_req`) are low.
- R2: `sym_code` is read only when `sym_valid` is 1. The codes are 0 = data zero, 1 = data one, 2 = idle D, 3 = filler L, and any value from 4 to 7 is invalid. A D arms the parser and clears the frame buffer, and further D symbols before data starts clear it again. Data symbols received before any D are ignored.
- R3: The first data symbol after D is the tag. A tag of 0 sends the next 16 data symbols, MSB first, to `dac_word`.
- R4: A tag of 1 sends the payload to a register write. `cfg_addr` is the first 8 payload bits and `cfg_data` is the last 8.
- R5: After the payload come P1 and then P0. P1 is 1 exactly when the tag plus the high byte (9 bits) hold an even number of ones. P0 is 1 exactly when the low byte holds an even number of ones. When the 19th data symbol is followed by D and both parity symbols match, the write is issued.
- R6: A frame of correct length with either parity symbol wrong raises `parity_err` and issues no write.
- R7: A D that arrives after between 1 and 18 data symbols raises `frame_err`.
- R8: A 20th data symbol raises `frame_err` at once and disarms the parser.
- R9: An L or an invalid symbol inside a frame raises `frame_err` and disarms the parser. An invalid symbol while armed does the same. After this, data symbols are ignored until the next D.
- R10: L symbols between frames, while armed or idle, produce no output and do not disturb the next frame.
- R11: `ack_req` pulses together with a write strobe only when `ack_en` was 1 on the closing D. It never pulses for an error.
- R12: Every strobe lasts one cycle and rises in the cycle after the clock edge that samples its symbol. At most one of the write and error strobes is high in any cycle.
- R13: The closing D of a frame also arms the next frame, so frames can follow each other back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | A symbol is present this cycle |
| sym_code | input | 3 | Symbol class (see R2) |
| ack_en | input | 1 | Allow acknowledge requests |
| dac_we | output | 1 | Converter word write strobe |
| dac_word | output | 16 | Converter word, held between writes |
| cfg_we | output | 1 | Register write strobe |
| cfg_addr | output | 8 | Register address, held between writes |
| cfg_data | output | 8 | Register data, held between writes |
| frame_err | output | 1 | Framing error pulse |
| parity_err | output | 1 | Parity error pulse |
| ack_req | output | 1 | Acknowledge request pulse |

## Verification
The hardest states to reach from the ports are the boundary lengths: a frame with exactly 19 data symbols that then receives a 20th, and a frame cut short by D at various counts. A third case is the disarmed state after an abort, where data must be silently ignored. The stimulus builds each frame symbol by symbol and can flip either parity symbol or append an extra bit. After each abort it sends stray data with no D, then a clean frame. Any unexpected strobe in that window is reported by the scoreboard.

// File: rtl/swfp_pkg.sv
package swfp_pkg;
   typedef enum logic [2:0] {
      SYM_ZERO = 3'd0,
      SYM_ONE  = 3'd1,
      SYM_IDLE = 3'd2,
      SYM_LOW  = 3'd3,
      SYM_BAD  = 3'd4
   } sym_e;

   typedef enum logic [1:0] {
      ST_WAIT,
      ST_ARMED,
      ST_BODY
   } st_e;
endpackage

// File: rtl/swfp_collect.sv
module swfp_collect #(
   parameter int FRAME_BITS = 19,
   localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  shift_en,
   input  logic                  bit_in,
   output logic [FRAME_BITS-1:0] bits,
   output logic [CNT_W-1:0]      count
);
   generate
      if (FRAME_BITS < 3) begin : g_bad_len
         $error("swfp_collect: FRAME_BITS too small");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits  <= '0;
         count <= '0;
      end else if (clr) begin
         bits  <= '0;
         count <= '0;
      end else if (shift_en) begin
         bits  <= {bits[FRAME_BITS-2:0], bit_in};
         count <= count + CNT_W'(1);
      end
   end

   // R8
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(FRAME_BITS));
endmodule

// File: rtl/swfp_slices.sv
module swfp_slices #(
   parameter int DATA_W        = 16,
   parameter bit EVEN_SETS_ONE = 1'b1
) (
   input  logic [DATA_W+2:0] bits,
   output logic              tag,
   output logic [DATA_W-1:0] payload,
   output logic              hi_ok,
   output logic              lo_ok
);
   localparam int HALF = DATA_W / 2;

   generate
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_w
         $error("swfp_slices: DATA_W must be even and at least 2");
      end
   endgenerate

   logic odd_hi, odd_lo, want_hi, want_lo;

   assign tag     = bits[DATA_W+2];
   assign payload = bits[DATA_W+1:2];
   assign odd_hi  = ^{tag, payload[DATA_W-1:HALF]};
   assign odd_lo  = ^payload[HALF-1:0];

   generate
      if (EVEN_SETS_ONE) begin : g_even_one
         assign want_hi = ~odd_hi;
         assign want_lo = ~odd_lo;
      end else begin : g_odd_one
         assign want_hi = odd_hi;
         assign want_lo = odd_lo;
      end
   endgenerate

   // R5: P1 is the second-to-last symbol, P0 the last
   assign hi_ok = (bits[1] == want_hi);
   assign lo_ok = (bits[0] == want_lo);
endmodule

// File: rtl/swire_frame_parser.sv
module swire_frame_parser
   import swfp_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter bit ACK_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sym_valid,
   input  logic [2:0]        sym_code,
   input  logic              ack_en,
   output logic              dac_we,
   output logic [DATA_W-1:0] dac_word,
   output logic              cfg_we,
   output logic [DATA_W/2-1:0] cfg_addr,
   output logic [DATA_W/2-1:0] cfg_data,
   output logic              frame_err,
   output logic              parity_err,
   output logic              ack_req
);
   localparam int FRAME_BITS = DATA_W + 3;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);
   localparam int HALF       = DATA_W / 2;

   st_e state, state_n;
   logic clr, shift_en;
   logic ev_dac, ev_cfg, ev_ferr, ev_perr;
   logic [FRAME_BITS-1:0] bits;
   logic [CNT_W-1:0] count;
   logic tag, hi_ok, lo_ok;
   logic [DATA_W-1:0] payload;
   logic c_idle, c_low, c_bit, full;

   swfp_collect #(.FRAME_BITS(FRAME_BITS)) i_collect (
      .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift_en),
      .bit_in(sym_code == SYM_ONE), .bits(bits), .count(count));

   swfp_slices #(.DATA_W(DATA_W), .EVEN_SETS_ONE(1'b1)) i_slices (
      .bits(bits), .tag(tag), .payload(payload), .hi_ok(hi_ok), .lo_ok(lo_ok));

   assign c_idle = (sym_code == SYM_IDLE);
   assign c_low  = (sym_code == SYM_LOW);
   assign c_bit  = (sym_code == SYM_ZERO) || (sym_code == SYM_ONE);
   assign full   = (count == CNT_W'(FRAME_BITS));

   always_comb begin
      state_n  = state;
      clr      = 1'b0;
      shift_en = 1'b0;
      ev_dac   = 1'b0;
      ev_cfg   = 1'b0;
      ev_ferr  = 1'b0;
      ev_perr  = 1'b0;
      if (sym_valid) begin
         unique case (state)
            ST_WAIT: begin
               if (c_idle) begin
                  state_n = ST_ARMED;
                  clr     = 1'b1;
               end
            end
            ST_ARMED: begin
               if (c_idle) begin
                  clr = 1'b1;
               end else if (c_bit) begin
                  shift_en = 1'b1;
                  state_n  = ST_BODY;
               end else if (!c_low) begin
                  ev_ferr = 1'b1;
                  state_n = ST_WAIT;
               end
            end
            ST_BODY: begin
               if (c_bit) begin
                  if (full) begin
                     ev_ferr = 1'b1;
                     clr     = 1'b1;
                     state_n = ST_WAIT;
                  end else begin
                     shift_en = 1'b1;
                  end
               end else if (c_idle) begin
                  clr     = 1'b1;
                  state_n = ST_ARMED;
                  if (!full)              ev_ferr = 1'b1;
                  else if (hi_ok && lo_ok) begin
                     ev_dac = ~tag;
                     ev_cfg = tag;
                  end else                ev_perr = 1'b1;
               end else begin
                  ev_ferr = 1'b1;
                  clr     = 1'b1;
                  state_n = ST_WAIT;
               end
            end
            default: state_n = ST_WAIT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_WAIT;
         dac_we     <= 1'b0;
         cfg_we     <= 1'b0;
         frame_err  <= 1'b0;
         parity_err <= 1'b0;
         dac_word   <= '0;
         cfg_addr   <= '0;
         cfg_data   <= '0;
      end else begin
         state      <= state_n;
         dac_we     <= ev_dac;
         cfg_we     <= ev_cfg;
         frame_err  <= ev_ferr;
         parity_err <= ev_perr;
         if (ev_dac) dac_word <= payload;
         if (ev_cfg) begin
            cfg_addr <= payload[DATA_W-1:HALF];
            cfg_data <= payload[HALF-1:0];
         end
      end
   end

   generate
      if (ACK_SUPPORT) begin : g_ack
         always_ff @(posedge clk) begin
            if (!rst_n) ack_req <= 1'b0;
            else        ack_req <= ack_en & (ev_dac | ev_cfg);
         end

         // R11
         ack_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ack_req |-> ((dac_we || cfg_we) && $past(ack_en)));
      end else begin : g_no_ack
         assign ack_req = 1'b0;
      end
   endgenerate

   // R12
   single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dac_we, cfg_we, frame_err, parity_err}));

   // R12
   event_needs_symbol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_we || cfg_we || frame_err || parity_err) |-> $past(sym_valid));

   // R12
   dac_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dac_we |=> !dac_we);

   // R5
   close_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_we || cfg_we || parity_err) |-> ($past(sym_code) == SYM_IDLE));
endmodule

// File: tb/test_swire_frame_parser.sv
module test_swire_frame_parser;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic rst_n = 1'b0, sym_valid = 1'b0, ack_en = 1'b0;
   logic [2:0] sym_code = 3'd4;
   logic dac_we, cfg_we, frame_err, parity_err, ack_req;
   logic [15:0] dac_word;
   logic [7:0] cfg_addr, cfg_data;

   swire_frame_parser i_swire_frame_parser (
      .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_code(sym_code),
      .ack_en(ack_en), .dac_we(dac_we), .dac_word(dac_word), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_data(cfg_data), .frame_err(frame_err),
      .parity_err(parity_err), .ack_req(ack_req));

   typedef struct {
      int          kind;
      logic [15:0] val;
      bit          ack;
      string       req;
   } exp_t;

   exp_t q[$];
   int   n_vec = 0, n_bad = 0;
   bit   done = 1'b0;

   task automatic put(int k, logic [15:0] v, bit a, string r);
      exp_t e;
      e.kind = k; e.val = v; e.ack = a; e.req = r;
      q.push_back(e);
   endtask

   task automatic sy(logic [2:0] c);
      @(negedge clk);
      sym_valid = 1'b1;
      sym_code  = c;
   endtask

   task automatic gap(int n);
      repeat (n) begin
         @(negedge clk);
         sym_valid = 1'b0;
         sym_code  = 3'd4;
      end
   endtask

   task automatic body(bit tag, logic [15:0] pl, bit f1, bit f0, bit gaps);
      bit p1, p0;
      p1 = ~(^{tag, pl[15:8]}) ^ f1;
      p0 = ~(^pl[7:0]) ^ f0;
      sy({2'b00, tag});
      for (int i = 15; i >= 0; i--) begin
         if (gaps) gap(2);
         sy({2'b00, pl[i]});
      end
      sy({2'b00, p1});
      sy({2'b00, p0});
   endtask

   task automatic expect_close(bit tag, logic [15:0] pl, bit f1, bit f0, string r);
      if (f1 || f0) put(3, 16'h0, 1'b0, r);
      else          put(tag ? 1 : 0, pl, ack_en, r);
   endtask

   task automatic frame(bit tag, logic [15:0] pl, bit f1, bit f0, string r);
      sy(3'd2);
      body(tag, pl, f1, f0, 1'b0);
      expect_close(tag, pl, f1, f0, r);
      sy(3'd2);
      gap(1);
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int nact, kind;
         logic [15:0] val;
         nact = int'(dac_we) + int'(cfg_we) + int'(frame_err) + int'(parity_err);
         kind = dac_we ? 0 : cfg_we ? 1 : frame_err ? 2 : 3;
         val  = dac_we ? dac_word : cfg_we ? {cfg_addr, cfg_data} : 16'h0;
         if (nact > 1) begin
            n_vec++; n_bad++;
            $display("FAIL R12 %0d strobes at once, expected at most 1", nact);
         end else if (nact == 1) begin
            n_vec++;
            if (q.size() == 0) begin
               n_bad++;
               $display("FAIL R10 unexpected output kind=%0d val=%h, expected none", kind, val);
            end else begin
               exp_t e;
               e = q.pop_front();
               if (kind != e.kind || val != e.val || ack_req != e.ack) begin
                  n_bad++;
                  $display("FAIL %s kind=%0d val=%h ack=%0b, expected kind=%0d val=%h ack=%0b",
                           e.req, kind, val, ack_req, e.kind, e.val, e.ack);
               end
            end
         end else if (ack_req) begin
            n_vec++; n_bad++;
            $display("FAIL R11 ack_req=1 without write, expected 0");
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      n_vec++;
      if ({dac_we, cfg_we, frame_err, parity_err, ack_req} !== 5'b0) begin
         n_bad++;
         $display("FAIL R1 strobes=%b in reset, expected 00000",
                  {dac_we, cfg_we, frame_err, parity_err, ack_req});
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_vec++;
      if ({dac_we, cfg_we, frame_err, parity_err, ack_req} !== 5'b0) begin
         n_bad++;
         $display("FAIL R1 strobes=%b after reset, expected 00000",
                  {dac_we, cfg_we, frame_err, parity_err, ack_req});
      end

      // R2: data before any D is ignored
      sy(3'd1); sy(3'd0); sy(3'd1); gap(2);
      // R3 / R4 / R5
      frame(1'b0, 16'hA55A, 1'b0, 1'b0, "R3");
      frame(1'b1, 16'h0308, 1'b0, 1'b0, "R4");
      frame(1'b0, 16'hFFFF, 1'b0, 1'b0, "R5");
      frame(1'b1, 16'h0001, 1'b0, 1'b0, "R5");
      frame(1'b0, 16'h8000, 1'b0, 1'b0, "R5");
      // R6
      frame(1'b0, 16'h1234, 1'b1, 1'b0, "R6");
      frame(1'b1, 16'h1234, 1'b0, 1'b1, "R6");
      // R7: short frame, then the closing D arms a good one
      sy(3'd2);
      for (int i = 0; i < 10; i++) sy(3'd1);
      put(2, 16'h0, 1'b0, "R7");
      sy(3'd2);
      body(1'b0, 16'h00C3, 1'b0, 1'b0, 1'b0);
      put(0, 16'h00C3, 1'b0, "R7");
      sy(3'd2); gap(1);
      // R8: 20th bit
      sy(3'd2);
      body(1'b0, 16'h5555, 1'b0, 1'b0, 1'b0);
      put(2, 16'h0, 1'b0, "R8");
      sy(3'd0);
      sy(3'd2); gap(1);
      // R9: L mid-frame, stray data ignored, then recover
      sy(3'd2);
      for (int i = 0; i < 5; i++) sy(3'd0);
      put(2, 16'h0, 1'b0, "R9");
      sy(3'd3);
      for (int i = 0; i < 19; i++) sy(3'd1);
      gap(2);
      frame(1'b1, 16'h0455, 1'b0, 1'b0, "R9");
      // R9: invalid code mid-frame
      sy(3'd2);
      for (int i = 0; i < 3; i++) sy(3'd1);
      put(2, 16'h0, 1'b0, "R9");
      sy(3'd6);
      gap(1);
      // R10: L between frames, repeated D before data (R2)
      sy(3'd3); sy(3'd3);
      sy(3'd2); sy(3'd3); sy(3'd2); sy(3'd2);
      body(1'b0, 16'h7E81, 1'b0, 1'b0, 1'b0);
      put(0, 16'h7E81, 1'b0, "R10");
      sy(3'd2);
      for (int i = 0; i < 4; i++) sy(3'd3);
      gap(1);
      // R13: back to back
      sy(3'd2);
      body(1'b1, 16'h05E8, 1'b0, 1'b0, 1'b0);
      put(1, 16'h05E8, 1'b0, "R13");
      sy(3'd2);
      body(1'b0, 16'hBEEF, 1'b0, 1'b0, 1'b0);
      put(0, 16'hBEEF, 1'b0, "R13");
      sy(3'd2);
      gap(1);
      // R11
      @(negedge clk); ack_en = 1'b1;
      frame(1'b0, 16'h4321, 1'b0, 1'b0, "R11");
      frame(1'b1, 16'h0102, 1'b0, 1'b0, "R11");
      frame(1'b0, 16'h4321, 1'b1, 1'b0, "R11");
      @(negedge clk); ack_en = 1'b0;
      frame(1'b1, 16'h0102, 1'b0, 1'b0, "R11");
      // R12: gaps in sym_valid inside a frame
      sy(3'd2);
      body(1'b0, 16'h0F0F, 1'b0, 1'b0, 1'b1);
      put(0, 16'h0F0F, 1'b0, "R12");
      sy(3'd2);
      gap(5);

      n_vec++;
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R12 %0d expected strobes missing, expected 0", q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule